// File: doc/BRIEF.md
# Bit-Oriented Frame Receiver with Partial-Byte Delivery

This block is the receive half of a bit-oriented serial link controller. It takes a serial bit stream together with a bit-enable strobe. It finds the flag octets that delimit frames, removes the zero bits the sender stuffed after runs of five ones, and drops a frame when seven or more ones arrive in a row. It strips the two trailing check octets, checks them against a CRC-16 (reflected 0x8408, preset all ones, good residue 0xF0B8), and assembles the payload LSB first into octets.

Every delivered octet is written into a 4-entry data FIFO and a 4-entry status FIFO in lockstep. The last entry of a frame carries an end-of-frame mark. A frame whose payload is not a whole number of octets delivers its trailing bits as one extra entry. That entry carries both the end-of-frame mark and a residual mark.

A small host register reports two sticky conditions: a CRC error bit that follows the status entry at the FIFO head, and an overrun bit.

Top module: `hdlc_rx_residual`

## Requirements
- R1: Payload bits between an opening and a closing flag (raw pattern 0,1,1,1,1,1,1,0) are delivered LSB first as octets, in order, on `rd_data_o`. `rd_valid_o` shows a non-empty FIFO, and a one-cycle `rd_i` advances to the next entry.
- R2: A 0 bit that follows five consecutive 1 bits inside a frame is removed and never appears in the payload.
- R3: Seven or more consecutive 1 bits abort the frame in progress. No entry is produced for the part of that frame not yet delivered, and reception resumes at the next flag.
- R4: The last 16 bits before the closing flag are taken as the check sequence and are never delivered. When the payload is whole octets, the last octet has `rd_eom_o`=1 and `rd_rbit_o`=0, and every earlier octet has both at 0.
- R5: A trailing partial octet of k bits (1..7) is delivered as one entry with `rd_eom_o`=1 and `rd_rbit_o`=1. Its first-received bit sits at position 8-k and its last at position 7. The lower 8-k bits are undefined.
- R6: Status register bit 3 (CRC error) becomes 1 when an end-of-frame entry whose CRC failed reaches the FIFO head, and the frame ended while `crc_chk_en_i` was 1.
- R7: While `crc_chk_en_i` is 0 at a frame's end, that frame never sets status bit 3.
- R8: Status bit 3 clears on a host write with bit 3 set, or when an end-of-frame entry with a good CRC reaches the FIFO head. Writing 0 to bit 3 leaves it unchanged.
- R9: Status bit 3 changes only when a new entry reaches the FIFO head or the host writes. A non-final entry at the head leaves it unchanged.
- R10: Status register bits 1 and 0 always read 0, whatever is written to them.
- R11: Both FIFOs hold 4 entries. A push while full drops that entry and sets status bit 2 (overrun). Bit 2 stays set until the host writes 1 to bit 2.
- R12: After reset both FIFOs are empty and the status register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Serial bit strobe; `bit_i` is taken when high |
| bit_i | input | 1 | Serial receive data |
| crc_chk_en_i | input | 1 | CRC check enable for the error bit |
| rd_i | input | 1 | Pop the head entry of both FIFOs |
| rd_valid_o | output | 1 | FIFO head entry present |
| rd_data_o | output | 8 | Head data octet |
| rd_eom_o | output | 1 | Head entry ends a frame |
| rd_rbit_o | output | 1 | Head entry is a partial octet |
| reg_we_i | input | 1 | Status register write strobe |
| reg_wdata_i | input | 8 | Write data; 1 in bit 3 or bit 2 clears that bit |
| reg_rdata_o | output | 8 | Status: bit 3 CRC error, bit 2 overrun, others 0 |

## Verification
The assertions assume that host writes do not land in the same cycle as a new entry reaching the FIFO head, and that a flag's closing 0 is not reused as the first 0 of the next flag. The stimulus keeps within both. It waits a few cycles after each frame and after each pop before it writes the register. It sends every flag as eight full raw bits. The assertions also assume that `rd_i` is raised only when `rd_valid_o` is high, and the bench pops only after it has seen a valid entry.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int BYTE_W   = 8;
  localparam int CRC_W    = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h8408;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;
  localparam logic [CRC_W-1:0] CRC_GOOD = 16'hF0B8;
  localparam int FLAG_RUN = 6;  // ones inside a flag
  localparam int STUF_RUN = 5;  // ones before a stuffed zero

  typedef struct packed {
    logic eom;
    logic rbit;
    logic crc_bad;
  } rx_stat_t;

  localparam int STAT_W = $bits(rx_stat_t);
endpackage

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc
  import hdlc_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic bit_i,
  output logic good_o
);
  logic [CRC_W-1:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q >> 1;
    if (crc_q[0] ^ bit_i) crc_d = crc_d ^ CRC_POLY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= CRC_SEED;
    else if (clr_i) crc_q <= CRC_SEED;
    else if (en_i)  crc_q <= crc_d;
  end

  assign good_o = (crc_q == CRC_GOOD);
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rp_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wp_q] <= din_i;
        wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      end
      if (do_pop) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> count_o == CW'(DEPTH));
  assert_count_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int JUNK_BITS = 6,   // flag bits that enter the data path before detection
  localparam int DL = CRC_W + JUNK_BITS,
  localparam int CW = $clog2(DL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              bit_i,
  input  logic              crc_chk_en_i,
  output logic              push_o,
  output logic [BYTE_W-1:0] push_data_o,
  output rx_stat_t          push_stat_o
);
  logic [2:0]        ones_q;
  logic              in_frame_q;
  logic [DL-1:0]     dl_q;
  logic [CW-1:0]     fcnt_q;
  logic [BYTE_W-1:0] acc_q, pend_q, acc_nxt;
  logic [2:0]        acnt_q;
  logic              pend_v_q;

  logic is_flag, is_abort, is_data, asm_en, crc_en, frame_ok, crc_good;

  always_comb begin
    is_flag  = bit_en_i && !bit_i && (ones_q == 3'(FLAG_RUN));
    is_abort = bit_en_i &&  bit_i && (ones_q == 3'(FLAG_RUN));
    is_data  = bit_en_i && in_frame_q && (ones_q < 3'(STUF_RUN));
    crc_en   = is_data && (fcnt_q >= CW'(JUNK_BITS));
    asm_en   = is_data && (fcnt_q == CW'(DL));
    frame_ok = is_flag && in_frame_q && (fcnt_q == CW'(DL));
    acc_nxt  = {dl_q[DL-1], acc_q[BYTE_W-1:1]};
  end

  hdlc_rx_crc u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (is_flag || is_abort),
    .en_i   (crc_en),
    .bit_i  (dl_q[JUNK_BITS-1]),
    .good_o (crc_good)
  );

  always_comb begin
    push_o = (asm_en && acnt_q == '0 && pend_v_q) ||
             (frame_ok && (acnt_q != '0 || pend_v_q));
    push_data_o          = (is_flag && acnt_q != '0) ? acc_q : pend_q;
    push_stat_o.eom      = is_flag;
    push_stat_o.rbit     = is_flag && (acnt_q != '0);
    push_stat_o.crc_bad  = is_flag && crc_chk_en_i && !crc_good;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q     <= '0;
      in_frame_q <= 1'b0;
      dl_q       <= '0;
      fcnt_q     <= '0;
      acc_q      <= '0;
      acnt_q     <= '0;
      pend_q     <= '0;
      pend_v_q   <= 1'b0;
    end else begin
      if (bit_en_i) ones_q <= !bit_i ? 3'd0 : (ones_q == 3'd7) ? 3'd7 : ones_q + 3'd1;
      if (is_flag || is_abort) begin
        in_frame_q <= is_flag;
        fcnt_q     <= '0;
        acnt_q     <= '0;
        pend_v_q   <= 1'b0;
      end else if (is_data) begin
        dl_q   <= {dl_q[DL-2:0], bit_i};
        fcnt_q <= (fcnt_q == CW'(DL)) ? fcnt_q : fcnt_q + 1'b1;
        if (asm_en) begin
          acc_q  <= acc_nxt;
          acnt_q <= acnt_q + 3'd1;
          if (acnt_q == 3'd7) begin
            pend_q   <= acc_nxt;
            pend_v_q <= 1'b1;
          end else if (acnt_q == '0) begin
            pend_v_q <= 1'b0;
          end
        end
      end
    end
  end

  assert_no_push_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> in_frame_q);
  assert_abort_leaves_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_abort |=> !in_frame_q && !pend_v_q);
  assert_fcnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcnt_q <= CW'(DL));
endmodule

// File: rtl/hdlc_rx_residual.sv
module hdlc_rx_residual
  import hdlc_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bit_en_i,
  input  logic        bit_i,
  input  logic        crc_chk_en_i,
  input  logic        rd_i,
  output logic        rd_valid_o,
  output logic [7:0]  rd_data_o,
  output logic        rd_eom_o,
  output logic        rd_rbit_o,
  input  logic        reg_we_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o
);
  localparam logic [7:0] CRC_ERR_MASK = 8'h08;
  localparam logic [7:0] OVR_MASK     = 8'h04;

  logic              push;
  logic [BYTE_W-1:0] push_data;
  rx_stat_t          push_stat, head_stat;
  logic [STAT_W-1:0] head_raw;
  logic              d_empty, d_full, s_empty, s_full;
  logic [CNT_W-1:0]  d_cnt, s_cnt;
  logic              seen_q, head_new, crc_err_q, ovr_q;
  logic              clr_crc, clr_ovr;

  hdlc_rx_deframer u_deframer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_en_i     (bit_en_i),
    .bit_i        (bit_i),
    .crc_chk_en_i (crc_chk_en_i),
    .push_o       (push),
    .push_data_o  (push_data),
    .push_stat_o  (push_stat)
  );

  hdlc_rx_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_data_fifo (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .push_i (push), .din_i (push_data), .pop_i (rd_i),
    .dout_o (rd_data_o), .empty_o (d_empty), .full_o (d_full), .count_o (d_cnt)
  );

  hdlc_rx_fifo #(.W(STAT_W), .DEPTH(FIFO_DEPTH)) u_stat_fifo (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .push_i (push), .din_i (push_stat), .pop_i (rd_i),
    .dout_o (head_raw), .empty_o (s_empty), .full_o (s_full), .count_o (s_cnt)
  );

  assign head_stat  = rx_stat_t'(head_raw);
  assign rd_valid_o = !d_empty;
  assign rd_eom_o   = head_stat.eom;
  assign rd_rbit_o  = head_stat.rbit;
  assign head_new   = rd_valid_o && !seen_q;
  assign clr_crc    = reg_we_i && ((reg_wdata_i & CRC_ERR_MASK) != '0);
  assign clr_ovr    = reg_we_i && ((reg_wdata_i & OVR_MASK) != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q    <= 1'b0;
      crc_err_q <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      seen_q <= rd_i ? 1'b0 : rd_valid_o;
      if (head_new && head_stat.eom) crc_err_q <= head_stat.crc_bad;
      else if (clr_crc)              crc_err_q <= 1'b0;
      if (push && (d_full || s_full)) ovr_q <= 1'b1;
      else if (clr_ovr)               ovr_q <= 1'b0;
    end
  end

  assign reg_rdata_o = {4'b0000, crc_err_q, ovr_q, 2'b00};

  assert_fifo_lockstep_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_cnt == s_cnt && d_empty == s_empty);
  assert_crc_err_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !head_new && !clr_crc |=> $stable(crc_err_q));
  assert_crc_rise_from_head_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crc_err_q) |-> $past(head_new && head_stat.eom && head_stat.crc_bad));
  assert_low_bits_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> reg_rdata_o[1:0] == 2'b00);
endmodule

// File: tb/hdlc_rx_residual_bench.sv
module hdlc_rx_residual_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, bit_v = 1'b0, chk_en = 1'b1, rd = 1'b0, we = 1'b0;
  logic [7:0] wdata = '0;
  logic rd_valid, rd_eom, rd_rbit;
  logic [7:0] rd_data, rdata;

  int n_checks = 0, n_err = 0, ones_run = 0;
  bit done = 0;
  logic [7:0] fb [8];

  always #(CLK_PERIOD / 2) clk = ~clk;

  hdlc_rx_residual u_hdlc_rx_residual (
    .clk_i (clk), .rst_ni (rst_n), .bit_en_i (bit_en), .bit_i (bit_v),
    .crc_chk_en_i (chk_en), .rd_i (rd), .rd_valid_o (rd_valid),
    .rd_data_o (rd_data), .rd_eom_o (rd_eom), .rd_rbit_o (rd_rbit),
    .reg_we_i (we), .reg_wdata_i (wdata), .reg_rdata_o (rdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    return (c[0] ^ b) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
  endfunction

  task automatic send_raw(input logic b);
    @(negedge clk); bit_v = b; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
  endtask

  task automatic send_flag();
    send_raw(1'b0);
    for (int i = 0; i < 6; i++) send_raw(1'b1);
    send_raw(1'b0);
    ones_run = 0;
  endtask

  task automatic send_data(input logic b);
    send_raw(b);
    if (b) begin
      ones_run++;
      if (ones_run == 5) begin send_raw(1'b0); ones_run = 0; end
    end else ones_run = 0;
  endtask

  task automatic send_frame(input int nb, input int k, input logic [7:0] rb, input bit bad);
    logic [15:0] c, fcs;
    c = 16'hFFFF;
    send_flag();
    for (int i = 0; i < nb; i++)
      for (int j = 0; j < 8; j++) begin c = crc_step(c, fb[i][j]); send_data(fb[i][j]); end
    for (int j = 0; j < k; j++) begin c = crc_step(c, rb[j]); send_data(rb[j]); end
    fcs = ~c;
    if (bad) fcs[0] = ~fcs[0];
    for (int j = 0; j < 16; j++) send_data(fcs[j]);
    send_flag();
    repeat (4) @(negedge clk);
  endtask

  task automatic pop();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0; wdata = '0;
    @(negedge clk);
  endtask

  task automatic expect_frame(input int nb, input int k, input logic [7:0] rb);
    logic [7:0] m;
    for (int i = 0; i < nb; i++) begin
      check(rd_valid === 1'b1, "R1 valid", int'(rd_valid), 1);
      check(rd_data === fb[i], "R1 R2 data", int'(rd_data), int'(fb[i]));
      check(rd_eom === (i == nb - 1 && k == 0), "R4 eom", int'(rd_eom), int'(i == nb - 1 && k == 0));
      check(rd_rbit === 1'b0, "R4 rbit on whole octet", int'(rd_rbit), 0);
      pop();
    end
    if (k > 0) begin
      m = 8'hFF >> (8 - k);
      check(rd_valid === 1'b1, "R5 valid", int'(rd_valid), 1);
      check(((rd_data >> (8 - k)) & m) === (rb & m), "R5 residual bits",
            int'((rd_data >> (8 - k)) & m), int'(rb & m));
      check(rd_eom === 1'b1 && rd_rbit === 1'b1, "R5 eom+rbit", int'({rd_eom, rd_rbit}), 3);
      pop();
    end
    check(rd_valid === 1'b0, "R4 no FCS octets delivered", int'(rd_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check(rd_valid === 1'b0, "R12 empty", int'(rd_valid), 0);
    check(rdata === 8'h00, "R12 status", int'(rdata), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R4 R5: sweep residual length, octet count and payload pattern
    for (int k = 0; k < 8; k++)
      for (int nb = 1; nb <= 3; nb++)
        for (int p = 0; p < 3; p++) begin
          logic [7:0] rb;
          for (int i = 0; i < nb; i++)
            case (p)
              0: fb[i] = (i == 0) ? 8'hFF : (i == 1) ? 8'h7E : 8'hF8;
              1: fb[i] = 8'(k * 29 + i * 53 + 7);
              default: fb[i] = 8'h3F << i;
            endcase
          rb = (p == 0) ? 8'hFF : 8'(k * 71 + nb * 13 + p);
          send_frame(nb, k, rb, 1'b0);
          expect_frame(nb, k, rb);
        end
    check(rdata[3] === 1'b0, "R8 good frames keep CRC error clear", int'(rdata[3]), 0);

    // R6 R9: bad CRC, error appears only when the final entry reaches the head
    fb[0] = 8'hA5; fb[1] = 8'h5A;
    send_frame(2, 0, 8'h00, 1'b1);
    check(rd_valid === 1'b1, "R9 head present", int'(rd_valid), 1);
    check(rdata[3] === 1'b0, "R9 non-final head leaves CRC error", int'(rdata[3]), 0);
    pop();
    check(rd_eom === 1'b1, "R4 eom", int'(rd_eom), 1);
    check(rdata[3] === 1'b1, "R6 CRC error set at head", int'(rdata[3]), 1);
    pop();
    check(rdata[3] === 1'b1, "R9 held after pop to empty", int'(rdata[3]), 1);

    // R8: write 0 no effect, write 1 clears
    reg_write(8'hF7);
    check(rdata[3] === 1'b1, "R8 write 0 to bit 3", int'(rdata[3]), 1);
    reg_write(8'h08);
    check(rdata[3] === 1'b0, "R8 write 1 clears", int'(rdata[3]), 0);

    // R8: good frame reaching the head clears
    fb[0] = 8'h11;
    send_frame(1, 0, 8'h00, 1'b1);
    check(rdata[3] === 1'b1, "R6 single-entry bad frame", int'(rdata[3]), 1);
    pop();
    fb[0] = 8'h22;
    send_frame(1, 3, 8'h05, 1'b0);
    pop();
    check(rdata[3] === 1'b0, "R8 good CRC at head clears", int'(rdata[3]), 0);
    check(rd_eom === 1'b1 && rd_rbit === 1'b1, "R5 eom+rbit", int'({rd_eom, rd_rbit}), 3);
    pop();

    // R7: check disabled
    chk_en = 1'b0;
    fb[0] = 8'h33;
    send_frame(1, 0, 8'h00, 1'b1);
    check(rd_data === 8'h33, "R7 data delivered", int'(rd_data), 8'h33);
    check(rdata[3] === 1'b0, "R7 disabled check never sets", int'(rdata[3]), 0);
    pop();
    chk_en = 1'b1;

    // R3: abort, then recovery
    send_flag();
    for (int i = 0; i < 24; i++) send_data(i[0]);
    for (int i = 0; i < 8; i++) send_raw(1'b1);
    send_raw(1'b0);
    send_flag();
    repeat (4) @(negedge clk);
    check(rd_valid === 1'b0, "R3 aborted frame produces nothing", int'(rd_valid), 0);
    fb[0] = 8'hC3; fb[1] = 8'h3C;
    send_frame(2, 2, 8'h02, 1'b0);
    expect_frame(2, 2, 8'h02);

    // R11: overrun
    for (int i = 0; i < 6; i++) fb[i] = 8'(8'h10 + i);
    send_frame(6, 0, 8'h00, 1'b0);
    check(rdata[2] === 1'b1, "R11 overrun set", int'(rdata[2]), 1);
    // R10: write to low bits ignored
    reg_write(8'h03);
    check(rdata[1:0] === 2'b00, "R10 low bits read 0", int'(rdata[1:0]), 0);
    check(rdata[2] === 1'b1, "R11 overrun sticky", int'(rdata[2]), 1);
    for (int i = 0; i < 4; i++) begin
      check(rd_data === fb[i] && rd_eom === 1'b0, "R11 kept entries",
            int'({rd_eom, rd_data}), int'(fb[i]));
      pop();
    end
    check(rd_valid === 1'b0, "R11 excess dropped", int'(rd_valid), 0);
    reg_write(8'h04);
    check(rdata === 8'h00, "R11 overrun cleared", int'(rdata), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule